// File: doc/BRIEF.md
# Register File and ALU Execute Stage

This block is the execute stage of a small 8-bit processor that finishes one instruction per clock. It holds four general registers and decodes the logic and arithmetic instruction classes from one instruction byte. In the same cycle it reads two operand registers, forms the result and commits it to the register file. All four register values are driven out so that neighbouring units can use them. Those units handle fetch, memory, stack and control flow.

The instruction byte has four fields. The class sits in bits [7:6]. The first operand index (s) sits in bits [5:4]. The second operand index (t) sits in bits [3:2]. The operation code sits in bits [1:0]. Register indices 0 to 3 select registers 0 to 3. Register 3 is the fixed destination of every two-operand result.

Top module: `exec_core`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all four registers to 0x00. The registers read 0x00 once reset is released and before any instruction is accepted.
- R2: For class 00, code 01 writes s AND t into register 3, and code 10 writes s OR t into register 3.
- R3: Class 00 with code 00 is a no-op. Bits [5:2] have no effect, and every register keeps its value.
- R4: Class 00 with code 11 writes the bitwise inverse of register t into the register indexed by s, which may be any of the four. No other register changes.
- R5: For class 01, code 00 writes s + t into register 3, and code 01 writes s − t into register 3. Both wrap modulo 256.
- R6: For class 01, code 10 writes s shifted left by the value of t into register 3, and code 11 writes s shifted right logically by that value. A shift amount of 8 or more gives 0x00.
- R7: An instruction with bit 7 set (class 10 or 11) changes no register.
- R8: While valid_i is low, no register changes, whatever the instruction byte holds.
- R9: A write lands on the rising clock edge. Its operands are the register values from before that edge, including when a source is also the destination.
- R10: An instruction that writes a two-operand result to register 3 leaves registers 0 to 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 8 | Instruction byte: class [7:6], s [5:4], t [3:2], code [1:0] |
| valid_i | input | 1 | High when instr_i is to be executed this cycle |
| regs_o | output | 32 | Register values, register n in bits [8n+7:8n] |

## Verification
The operand read and the write-back can fall in the same cycle on the same register. This happens when an instruction reads register 3 and also writes its result there, or when an inversion writes back into its own source. The bench provokes this with add and shift instructions that take register 3 as an operand, and with inversions of register 1 into itself and register 3 into itself. It judges each result against the value computed from the register contents before the edge, never from the contents after it.

// File: rtl/exec_core.sv
module exec_core #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          instr_i,
  input  logic                valid_i,
  output logic [4*DATA_W-1:0] regs_o
);

  localparam int REG_CNT = 4;
  localparam int SHW     = $clog2(DATA_W);
  localparam logic [1:0] RES_IDX = 2'd3;

  logic [DATA_W-1:0] rf [REG_CNT];

  wire [1:0] cls  = instr_i[7:6];
  wire [1:0] sidx = instr_i[5:4];
  wire [1:0] tidx = instr_i[3:2];
  wire [1:0] code = instr_i[1:0];

  wire [DATA_W-1:0] sval = rf[sidx];
  wire [DATA_W-1:0] tval = rf[tidx];

  wire              big_shift = 32'(tval) >= 32'(DATA_W);
  wire [SHW-1:0]    shamt     = tval[SHW-1:0];

  logic [DATA_W-1:0] result;
  logic [1:0]        dest;
  logic              wen;

  always_comb begin
    result = '0;
    dest   = RES_IDX;
    wen    = 1'b0;
    if (valid_i) begin
      unique case (cls)
        2'b00: begin
          unique case (code)
            2'b00: wen = 1'b0;
            2'b01: begin wen = 1'b1; result = sval & tval; end
            2'b10: begin wen = 1'b1; result = sval | tval; end
            2'b11: begin wen = 1'b1; result = ~tval; dest = sidx; end
          endcase
        end
        2'b01: begin
          wen = 1'b1;
          unique case (code)
            2'b00: result = sval + tval;
            2'b01: result = sval - tval;
            2'b10: result = big_shift ? '0 : (sval << shamt);
            2'b11: result = big_shift ? '0 : (sval >> shamt);
          endcase
        end
        default: wen = 1'b0;
      endcase
    end
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rf[i] <= '0;
      else if (wen && dest == 2'(i))
        rf[i] <= result;
    end
    assign regs_o[i*DATA_W +: DATA_W] = rf[i];
  end

  wire [DATA_W-1:0] r0 = regs_o[0*DATA_W +: DATA_W];
  wire [DATA_W-1:0] r1 = regs_o[1*DATA_W +: DATA_W];
  wire [DATA_W-1:0] r2 = regs_o[2*DATA_W +: DATA_W];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> regs_o == '0); // R1

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[7:6] == 2'b00 && instr_i[1:0] == 2'b00) |=> $stable(regs_o)); // R3

  AST_UPPER_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[7]) |=> $stable(regs_o)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(regs_o)); // R8

  AST_LOW_REGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !instr_i[7] && instr_i[6:0] != 7'b0 &&
     !(instr_i[7:6] == 2'b00 && instr_i[1:0] == 2'b11))
    |=> ($stable(r0) && $stable(r1) && $stable(r2))); // R10

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones({r0 != $past(r0), r1 != $past(r1), r2 != $past(r2),
                         regs_o[3*DATA_W +: DATA_W] != $past(regs_o[3*DATA_W +: DATA_W])}) <= 1); // R4

endmodule

// File: tb/sim_exec_core.sv
module sim_exec_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  instr_i = 8'h00;
  logic        valid_i = 1'b0;
  logic [31:0] regs_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exec_core u0 (.clk(clk), .rst_n(rst_n), .instr_i(instr_i), .valid_i(valid_i), .regs_o(regs_o));

  localparam int N = 25;
  // {valid, instr, expected {r3,r2,r1,r0}}
  localparam logic [40:0] VEC [N] = '{
    {1'b1, 8'h03, 32'h00_00_00_FF},  // R4 invert r0 into itself
    {1'b1, 8'h51, 32'h01_00_00_FF},  // R5 sub wraps 0-FF
    {1'b1, 8'h1F, 32'h01_00_FE_FF},  // R4 invert r3 into r1
    {1'b1, 8'h17, 32'h01_00_01_FF},  // R9 invert r1 into itself
    {1'b1, 8'h46, 32'hFE_00_01_FF},  // R6 shift left by 1
    {1'b1, 8'h74, 32'hFF_00_01_FF},  // R9 add reads old r3
    {1'b1, 8'h44, 32'h00_00_01_FF},  // R5 add wraps
    {1'b1, 8'h2F, 32'h00_FF_01_FF},  // R4 invert into r2
    {1'b1, 8'h67, 32'h7F_FF_01_FF},  // R6 logical right
    {1'b1, 8'h2F, 32'h7F_80_01_FF},  // R4
    {1'b1, 8'h21, 32'h80_80_01_FF},  // R2 and
    {1'b1, 8'h1A, 32'h81_80_01_FF},  // R2 or
    {1'b1, 8'h38, 32'h81_80_01_FF},  // R3 nop with junk fields
    {1'b1, 8'hBF, 32'h81_80_01_FF},  // R7 class 10
    {1'b1, 8'hC7, 32'h81_80_01_FF},  // R7 class 11
    {1'b1, 8'h4A, 32'h00_80_01_FF},  // R6 amount 0x80
    {1'b1, 8'h40, 32'hFE_80_01_FF},  // R10 add r0+r0
    {1'b1, 8'h43, 32'h00_80_01_FF},  // R6 amount 0xFF
    {1'b1, 8'h65, 32'h7F_80_01_FF},  // R5 sub order
    {1'b1, 8'h7C, 32'hFE_80_01_FF},  // R9 r3+r3
    {1'b1, 8'h76, 32'hFC_80_01_FF},  // R9 r3<<r1
    {1'b1, 8'h3F, 32'h03_80_01_FF},  // R4 invert r3 into itself
    {1'b1, 8'h5E, 32'h08_80_01_FF},  // R6 shift by 3
    {1'b1, 8'h4F, 32'h00_80_01_FF},  // R6 amount exactly 8
    {1'b0, 8'h40, 32'h00_80_01_FF}   // R8 valid low
  };

  task automatic check(input string req, input logic [31:0] exp);
    tests++;
    if (regs_o !== exp) begin
      fails++;
      $display("FAIL %s: regs=%h expected=%h", req, regs_o, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: timeout");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'h0);

    for (int i = 0; i < N; i++) begin
      valid_i = VEC[i][40];
      instr_i = VEC[i][39:32];
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i][31:0]);
    end

    valid_i = 1'b0;
    instr_i = 8'h03;
    @(negedge clk);
    check("R8 invert while idle", 32'h00_80_01_FF);

    valid_i = 1'b1;
    instr_i = 8'h84;
    @(negedge clk);
    check("R7 class 10 code 00", 32'h00_80_01_FF);

    instr_i = 8'h3C;
    repeat (3) @(negedge clk);
    check("R3 repeated nop", 32'h00_80_01_FF);

    instr_i = 8'h00;
    rst_n = 1'b0;
    #2;
    check("R1 async clear mid-run", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    valid_i = 1'b0;
    @(negedge clk);
    check("R1 cleared after release", 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule